// File: doc/BRIEF.md
# USB Device Link State Monitor

This block follows the condition of a full-speed USB link from the device side. It takes the decoded line state, already reduced to single-ended zero, idle J or K, together with a one-cycle pulse from the packet logic each time a start-of-frame token arrives. From these it keeps a three-valued link state (disconnected, active, suspended). It also emits a one-cycle event when it sees a bus reset, a suspend, a resume or a missing host. All durations are measured in microsecond ticks, which an internal divider derives from the system clock.

A register file or interrupt controller next to the block turns the events into interrupt bits. The link state output lets the device core decide whether to answer tokens. While the enable input is low the monitor is inert: its timers stay at zero, no event fires and the link reads as disconnected.

Top module: `usb_link_monitor`

## Requirements
- R1: While `rst_n` is low, or at any clock edge where `en_i` is low, the link state becomes 0 (disconnected), every duration count returns to zero, and no event output is high in the following cycle.
- R2: Line codes on `line_i` are 0 = SE0, 1 = J, 2 = K and 3 = invalid. The code passes through two synchronizer flops before use. A microsecond tick occurs every `CLKS_PER_US` enabled cycles.
- R3: A run of synchronized SE0 that spans `RESET_US`+1 ticks raises `evt_reset_o` for one cycle and sets the link state to 1 (active). This works from any link state.
- R4: A detected reset restarts the host-lost and idle-J timers from zero.
- R5: While the link is active, a run of synchronized J that spans `SUSPEND_US`+1 ticks raises `evt_suspend_o` for one cycle and sets the link state to 2 (suspended).
- R6: While the link is suspended, the first synchronized code other than J (K, SE0 or 3) raises `evt_resume_o` for one cycle and sets the link state to 1.
- R7: While the link is active, `HOSTLOST_US` ticks without a pulse on `sof_i` raise `evt_hostlost_o` for one cycle. The link stays active, and the event does not fire again until a new start-of-frame pulse restarts the count.
- R8: Every `sof_i` pulse sets the host-lost count back to zero.
- R9: A change of line state ends the current SE0 or J run, and its count starts again from zero. Each run raises its event at most once, however long it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enables detection. Low clears the block. |
| line_i | input | 2 | Decoded line state: 0 SE0, 1 J, 2 K, 3 invalid |
| sof_i | input | 1 | One-cycle pulse per received start-of-frame token |
| evt_reset_o | output | 1 | Bus reset detected |
| evt_suspend_o | output | 1 | Suspend detected |
| evt_resume_o | output | 1 | Resume detected |
| evt_hostlost_o | output | 1 | Start-of-frame missing too long |
| link_state_o | output | 2 | 0 disconnected, 1 active, 2 suspended |

## Verification
The link is driven with SE0 runs that stop just short of the reset threshold and are broken by a K, and with SE0 runs that are long enough. This tells a correct threshold and run restart apart from an off-by-one or a count that is never cleared. Regular frames with start-of-frame pulses are set against K activity with no frames. That separates the host-lost watchdog from the suspend timer, and it shows the single firing of the host-lost event. Suspended links are woken with K, with the invalid code and with a long SE0, and a reset is placed in the middle of a host-lost interval. Together these show which line codes count as activity, and that a reset restarts the timers.

// File: rtl/usb_lnk_pkg.sv
package usb_lnk_pkg;

  typedef enum logic [1:0] {
    LINE_SE0 = 2'd0,
    LINE_J   = 2'd1,
    LINE_K   = 2'd2,
    LINE_BAD = 2'd3
  } line_e;

  typedef enum logic [1:0] {
    LINK_DISC   = 2'd0,
    LINK_ACTIVE = 2'd1,
    LINK_SUSP   = 2'd2
  } link_e;

  // "longer than N us" means a run must cover N+1 ticks
  function automatic int unsigned beyond_us(input int unsigned us);
    return us + 1;
  endfunction

  // width needed to hold values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/usb_lnk_sync.sv
module usb_lnk_sync #(
  parameter int          W      = 2,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] IDLE  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] src;
    if (s == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = stg[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stg[s] <= IDLE;
      else if (clr) stg[s] <= IDLE;
      else          stg[s] <= src;
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/usb_lnk_tick.sv
module usb_lnk_tick #(
  parameter int unsigned DIV = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick_o
);
  import usb_lnk_pkg::*;

  localparam int unsigned CW = cnt_width(DIV - 1);

  logic [CW-1:0] div_q;

  assign tick_o = en && (div_q == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (!en)    div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

endmodule

// File: rtl/usb_lnk_timer.sv
module usb_lnk_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic hit_o
);
  import usb_lnk_pkg::*;

  localparam int unsigned CW = cnt_width(LIMIT);

  logic [CW-1:0] cnt_q;
  logic          at_limit;

  assign at_limit = (cnt_q == CW'(LIMIT));
  assign hit_o    = !clr && tick && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr)               cnt_q <= '0;
    else if (tick && !at_limit) cnt_q <= cnt_q + 1'b1;
  end

  // one firing per interval: after a hit the count is parked or cleared
  assert_single_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !hit_o);

endmodule

// File: rtl/usb_link_monitor.sv
module usb_link_monitor #(
  parameter int unsigned CLKS_PER_US = 48,
  parameter int unsigned RESET_US    = 3,
  parameter int unsigned SUSPEND_US  = 3000,
  parameter int unsigned HOSTLOST_US = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic [1:0] line_i,
  input  logic       sof_i,
  output logic       evt_reset_o,
  output logic       evt_suspend_o,
  output logic       evt_resume_o,
  output logic       evt_hostlost_o,
  output logic [1:0] link_state_o
);
  import usb_lnk_pkg::*;

  localparam int unsigned RESET_TICKS = beyond_us(RESET_US);
  localparam int unsigned SUSP_TICKS  = beyond_us(SUSPEND_US);
  localparam int unsigned LOST_TICKS  = HOSTLOST_US;

  logic [1:0] line_sync;
  line_e      line_s;
  logic       us_tick;
  link_e      link_q, link_d;

  // named internal events
  logic se0_clr, idle_clr, lost_clr;
  logic rst_hit, susp_hit, lost_hit, resume_hit;

  usb_lnk_sync #(.W(2), .STAGES(2), .IDLE(2'(LINE_J))) u_sync (
    .clk (clk), .rst_n (rst_n), .clr (!en_i), .d (line_i), .q (line_sync)
  );

  assign line_s = line_e'(line_sync);

  usb_lnk_tick #(.DIV(CLKS_PER_US)) u_tick (
    .clk (clk), .rst_n (rst_n), .en (en_i), .tick_o (us_tick)
  );

  assign se0_clr  = !en_i || (line_s != LINE_SE0);
  assign idle_clr = !en_i || (link_q != LINK_ACTIVE) || (line_s != LINE_J) || rst_hit;
  assign lost_clr = !en_i || (link_q != LINK_ACTIVE) || sof_i || rst_hit;

  usb_lnk_timer #(.LIMIT(RESET_TICKS)) u_se0_tmr (
    .clk (clk), .rst_n (rst_n), .clr (se0_clr), .tick (us_tick), .hit_o (rst_hit)
  );

  usb_lnk_timer #(.LIMIT(SUSP_TICKS)) u_idle_tmr (
    .clk (clk), .rst_n (rst_n), .clr (idle_clr), .tick (us_tick), .hit_o (susp_hit)
  );

  usb_lnk_timer #(.LIMIT(LOST_TICKS)) u_lost_tmr (
    .clk (clk), .rst_n (rst_n), .clr (lost_clr), .tick (us_tick), .hit_o (lost_hit)
  );

  assign resume_hit = en_i && (link_q == LINK_SUSP) && (line_s != LINE_J);

  always_comb begin
    link_d = link_q;
    if (rst_hit)         link_d = LINK_ACTIVE;
    else if (resume_hit) link_d = LINK_ACTIVE;
    else if (susp_hit)   link_d = LINK_SUSP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q         <= LINK_DISC;
      evt_reset_o    <= 1'b0;
      evt_suspend_o  <= 1'b0;
      evt_resume_o   <= 1'b0;
      evt_hostlost_o <= 1'b0;
    end else if (!en_i) begin
      link_q         <= LINK_DISC;
      evt_reset_o    <= 1'b0;
      evt_suspend_o  <= 1'b0;
      evt_resume_o   <= 1'b0;
      evt_hostlost_o <= 1'b0;
    end else begin
      link_q         <= link_d;
      evt_reset_o    <= rst_hit;
      evt_suspend_o  <= susp_hit;
      evt_resume_o   <= resume_hit;
      evt_hostlost_o <= lost_hit;
    end
  end

  assign link_state_o = link_q;

  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (link_state_o == 2'd0) && !evt_reset_o && !evt_suspend_o
              && !evt_resume_o && !evt_hostlost_o);

  assert_reset_lands_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_reset_o |-> (link_state_o == 2'd1));

  assert_suspend_from_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_suspend_o |-> (link_state_o == 2'd2) && ($past(link_state_o) == 2'd1));

  assert_resume_from_susp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_resume_o |-> (link_state_o == 2'd1) && ($past(link_state_o) == 2'd2));

  assert_hostlost_when_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hostlost_o |-> ($past(link_state_o) == 2'd1));

  assert_sof_blocks_hostlost_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sof_i |=> !evt_hostlost_o);

endmodule

// File: tb/sim_usb_link_monitor.sv
`timescale 1ns/1ps
module sim_usb_link_monitor;

  localparam int CPU  = 2;
  localparam int RUS  = 3;
  localparam int SUS  = 3000;
  localparam int HLUS = 4096;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_i = 1'b0;
  logic [1:0] line_i = 2'd1;
  logic       sof_i = 1'b0;
  logic       evt_reset_o, evt_suspend_o, evt_resume_o, evt_hostlost_o;
  logic [1:0] link_state_o;

  always #5 clk = ~clk;

  usb_link_monitor #(.CLKS_PER_US(CPU), .RESET_US(RUS), .SUSPEND_US(SUS),
                     .HOSTLOST_US(HLUS)) u0 (
    .clk (clk), .rst_n (rst_n), .en_i (en_i), .line_i (line_i), .sof_i (sof_i),
    .evt_reset_o (evt_reset_o), .evt_suspend_o (evt_suspend_o),
    .evt_resume_o (evt_resume_o), .evt_hostlost_o (evt_hostlost_o),
    .link_state_o (link_state_o)
  );

  int tests = 0;
  int fails = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: microsecond budget per run, per requirement
  int div = 0, run_se0 = 0, run_j = 0, since_sof = 0;
  int pipe[$] = '{1, 1};
  int st = 0;
  bit m_rst, m_sus, m_res, m_hl;

  always @(posedge clk) begin
    if (!rst_n || !en_i) begin
      div = 0; run_se0 = 0; run_j = 0; since_sof = 0; st = 0;
      pipe = '{1, 1};
      m_rst = 0; m_sus = 0; m_res = 0; m_hl = 0;
    end else begin
      int  ln;
      bit  tk, r, s, rs, h;
      ln = pipe[1];
      tk = (div == CPU - 1);
      // R3: reset fires on the tick that makes the SE0 run exceed RUS us
      r  = (ln == 0) && tk && (run_se0 + 1 == RUS + 1);
      // R6: any non-J while suspended
      rs = (st == 2) && (ln != 1);
      // R5
      s  = (st == 1) && (ln == 1) && tk && (run_j + 1 == SUS + 1);
      // R7/R8
      h  = (st == 1) && !sof_i && !r && tk && (since_sof + 1 == HLUS);
      if (ln != 0) run_se0 = 0;
      else if (tk && run_se0 <= RUS) run_se0++;
      if (st != 1 || ln != 1 || r) run_j = 0;
      else if (tk && run_j <= SUS) run_j++;
      if (st != 1 || sof_i || r) since_sof = 0;
      else if (tk && since_sof < HLUS) since_sof++;
      if (r || rs) st = 1;
      else if (s) st = 2;
      div = tk ? 0 : div + 1;
      void'(pipe.pop_back());
      pipe.push_front(int'(line_i));
      m_rst = r; m_sus = s; m_res = rs; m_hl = h;
    end
  end

  int n_rst = 0, n_sus = 0, n_res = 0, n_hl = 0;

  always @(negedge clk) begin
    check("R3", "evt_reset", int'(evt_reset_o), int'(m_rst));
    check("R5", "evt_suspend", int'(evt_suspend_o), int'(m_sus));
    check("R6", "evt_resume", int'(evt_resume_o), int'(m_res));
    check("R7", "evt_hostlost", int'(evt_hostlost_o), int'(m_hl));
    check("R1", "link_state", int'(link_state_o), st);
    if (evt_reset_o)    n_rst++;
    if (evt_suspend_o)  n_sus++;
    if (evt_resume_o)   n_res++;
    if (evt_hostlost_o) n_hl++;
  end

  task automatic zero_counts();
    n_rst = 0; n_sus = 0; n_res = 0; n_hl = 0;
  endtask

  task automatic hold(input logic [1:0] code, input int us);
    line_i = code;
    repeat (us * CPU) @(negedge clk);
  endtask

  // a frame: short packet activity, then the token pulse, then idle J
  task automatic frame(input int us);
    hold(2'd2, 1); hold(2'd1, 1); hold(2'd0, 1);
    line_i = 2'd1;
    sof_i = 1'b1; @(negedge clk); sof_i = 1'b0;
    hold(2'd1, us - 3);
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1", "state in reset", int'(link_state_o), 0);
    rst_n = 1'b1;
    // disabled: long SE0 must be ignored
    zero_counts(); hold(2'd0, 20);
    check("R1", "resets while disabled", n_rst, 0);
    check("R1", "state while disabled", int'(link_state_o), 0);
    en_i = 1'b1;
    // R9: SE0 runs broken before the threshold
    zero_counts(); hold(2'd1, 50);
    hold(2'd0, 2); hold(2'd2, 1); hold(2'd0, 2); hold(2'd1, 5);
    check("R9", "short SE0 runs", n_rst, 0);
    check("R2", "idle J keeps disconnected", int'(link_state_o), 0);
    hold(2'd0, 20); hold(2'd1, 5);
    check("R3", "long SE0 reset count", n_rst, 1);
    check("R3", "state after reset", int'(link_state_o), 1);
    // R8: frames keep the watchdog quiet
    zero_counts();
    for (int i = 0; i < 5; i++) frame(1000);
    check("R8", "no hostlost with frames", n_hl, 0);
    check("R5", "no suspend with frames", n_sus, 0);
    // R7: activity but no frames
    zero_counts();
    for (int i = 0; i < 10; i++) begin hold(2'd2, 1); hold(2'd1, 499); end
    check("R7", "hostlost fires once", n_hl, 1);
    check("R7", "still active", int'(link_state_o), 1);
    // R5: idle into suspend, once
    zero_counts(); frame(10); hold(2'd1, 3600);
    check("R5", "suspend count", n_sus, 1);
    check("R5", "state suspended", int'(link_state_o), 2);
    // R6: K wakes
    zero_counts(); hold(2'd2, 1); hold(2'd1, 5);
    check("R6", "resume on K", n_res, 1);
    check("R6", "active after K", int'(link_state_o), 1);
    // R2: invalid code counts as activity
    hold(2'd1, 3100);
    zero_counts(); hold(2'd3, 1); hold(2'd1, 5);
    check("R2", "resume on code 3", n_res, 1);
    // R3: reset out of suspend
    hold(2'd1, 3100);
    check("R5", "suspended again", int'(link_state_o), 2);
    zero_counts(); hold(2'd0, 20); hold(2'd1, 5);
    check("R3", "resume then reset", n_res + 10 * n_rst, 11);
    check("R3", "active after reset", int'(link_state_o), 1);
    // R4: reset restarts the host-lost count
    frame(10); hold(2'd1, 2000);
    zero_counts(); hold(2'd0, 20); hold(2'd1, 2500);
    check("R4", "no hostlost after reset", n_hl, 0);
    check("R4", "no suspend after reset", n_sus, 0);
    // R1: dropping enable
    en_i = 1'b0; @(negedge clk); @(negedge clk);
    check("R1", "state after disable", int'(link_state_o), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule